// File: doc/BRIEF.md
# Ethernet receive address and type filter

This block sits on the byte stream of a receive MAC and decides, once per frame, whether the frame should go on to the downstream FIFO. Bytes arrive one per cycle, starting with the first byte after the start-of-frame delimiter. The first six bytes are the destination address, sent least significant byte first. Bytes 13 and 14 carry the length/type value, sent most significant byte first.

Software programs four destination-address slots and four type slots through a 32-bit write port. An address slot has two halves. Writing its low half disarms the slot. Writing its high half arms it again. A type slot takes part in matching only while bit 31 of its value is set.

The frame is accepted when any armed address slot or any enabled type slot matches. One exception applies: the frame is refused when the MAC is sending in half duplex while the address arrives, unless a control input allows reception in that state. The verdict comes out as a one-cycle strobe. With it come the accept bit, the per-slot hit flags, and the multicast and broadcast indications.

Top module: `eth_rx_filter`

## Requirements
- R1: After reset every address slot is disarmed and every type slot is disabled, so the next frame is refused. `dec_valid` is 0 out of reset.
- R2: For address slot k, the low register sits at `cfg_addr` 2k and the high register at 2k+1. Low bits 7:0 hold address byte 0 (the first byte received), bits 15:8 hold byte 1, bits 23:16 hold byte 2 and bits 31:24 hold byte 3. High bits 7:0 hold byte 4 and bits 15:8 hold byte 5. For example, low 0x87654321 with high 0x0000CBA9 matches the bytes 21 43 65 87 A9 CB.
- R3: A write to a slot's low register disarms that slot. A write to its high register arms it. A disarmed slot never reports a hit.
- R4: Type slot j sits at `cfg_addr` 8+j. Bit 31 enables the slot and bits 15:0 are compared with frame bytes 13 (high) and 14 (low). For example, 0x80004321 matches the bytes 43 then 21.
- R5: `dec_accept` is the OR of all address hits and all type hits. Both hit vectors are reported, with bit k standing for slot k.
- R6: A frame of 14 or more bytes gives exactly one `dec_valid` pulse, in the cycle after byte 14 is presented. Later bytes and the end of frame add no pulse. Outside the pulse, all decision outputs are 0.
- R7: A frame that ends before byte 14 is decided in the cycle after `rx_eof`, using address hits only. A frame shorter than six bytes is refused.
- R8: When `hd_mode` and `tx_busy` are both 1 while byte 6 is received, and `hd_rx_allow` is 0, the frame is refused whatever matches. With `hd_rx_allow` at 1, or with `tx_busy` at 0, matching decides as usual.
- R9: `dec_group` equals bit 0 of address byte 0 (1 means multicast). `dec_bcast` is 1 only when all 48 address bits are 1.
- R10: A configuration write made during a frame takes effect from the next frame onward.
- R11: Writes to `cfg_addr` 12 to 15 change nothing. A type slot whose bit 31 is 0 never hits, even when its value matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| hd_mode | input | 1 | MAC runs in half duplex |
| tx_busy | input | 1 | MAC is transmitting |
| hd_rx_allow | input | 1 | Allow reception while sending in half duplex |
| rx_valid | input | 1 | `rx_data` holds a frame byte |
| rx_sof | input | 1 | Marks the first byte of a frame (with `rx_valid`) |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame pulse, with no data |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Forward the frame |
| dec_addr_hit | output | 4 | Address slots that matched |
| dec_type_hit | output | 4 | Type slots that matched |
| dec_group | output | 1 | Destination is multicast |
| dec_bcast | output | 1 | Destination is broadcast |

## Verification
The bench targets the arming sequence. It rewrites only a low half and then expects a refusal, because a design that armed a slot on any write would still accept. It times the decision strobe against byte 14 and against end of frame. A design that decided at byte 13, or that also pulsed at end of frame, would show a missing or doubled strobe.

Short frames check that type bytes are not used before they arrive. The half-duplex cases check that the override and the transmit state each lift the block. A write made during a frame must leave that frame's verdict unchanged, so a design that compared against live registers would flip it.

// File: rtl/eth_filt_pkg.sv
package eth_filt_pkg;
   localparam int BYTE_W      = 8;
   localparam int DA_W        = 48;
   localparam int TY_W        = 16;
   localparam int CNT_W       = 4;
   localparam int IDX_DA_LAST = 5;
   localparam int IDX_TY_HI   = 12;
   localparam int IDX_TY_LO   = 13;
   localparam int TY_EN_BIT   = 31;
endpackage

// File: rtl/eth_filt_regs.sv
module eth_filt_regs
   import eth_filt_pkg::*;
#(
   parameter int N_ADDR = 4,
   parameter int N_TYPE = 4,
   parameter int AW     = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [AW-1:0]                addr,
   input  logic [31:0]                  wdata,
   input  logic                         take,
   output logic [N_ADDR-1:0][DA_W-1:0] snap_da,
   output logic [N_ADDR-1:0]            snap_act,
   output logic [N_TYPE-1:0][TY_W-1:0] snap_ty,
   output logic [N_TYPE-1:0]            snap_ten
);
   for (genvar k = 0; k < N_ADDR; k++) begin : g_aslot
      localparam logic [AW-1:0] LO_A = AW'(2*k);
      localparam logic [AW-1:0] HI_A = AW'(2*k+1);
      logic [31:0]       lo_q;
      logic [15:0]       hi_q;
      logic              act_q;
      logic [DA_W-1:0]   s_da;
      logic              s_act;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            act_q <= 1'b0;
            s_da  <= '0;
            s_act <= 1'b0;
         end else begin
            if (we && addr == LO_A) begin
               lo_q  <= wdata;
               act_q <= 1'b0;
            end else if (we && addr == HI_A) begin
               hi_q  <= wdata[15:0];
               act_q <= 1'b1;
            end
            if (take) begin
               s_da  <= {hi_q, lo_q};
               s_act <= act_q;
            end
         end
      end
      assign snap_da[k]  = s_da;
      assign snap_act[k] = s_act;

      p_lo_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (we && addr == LO_A) |=> !act_q);
      p_hi_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (we && addr == HI_A) |=> act_q);
   end

   for (genvar j = 0; j < N_TYPE; j++) begin : g_tslot
      localparam logic [AW-1:0] TY_A = AW'(2*N_ADDR + j);
      logic [TY_W-1:0] tv_q;
      logic            ten_q;
      logic [TY_W-1:0] s_tv;
      logic            s_ten;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tv_q  <= '0;
            ten_q <= 1'b0;
            s_tv  <= '0;
            s_ten <= 1'b0;
         end else begin
            if (we && addr == TY_A) begin
               tv_q  <= wdata[TY_W-1:0];
               ten_q <= wdata[TY_EN_BIT];
            end
            if (take) begin
               s_tv  <= tv_q;
               s_ten <= ten_q;
            end
         end
      end
      assign snap_ty[j]  = s_tv;
      assign snap_ten[j] = s_ten;
   end
endmodule

// File: rtl/eth_filt_cmp.sv
module eth_filt_cmp
   import eth_filt_pkg::*;
#(
   parameter int N_ADDR = 4,
   parameter int N_TYPE = 4
) (
   input  logic [DA_W-1:0]              da,
   input  logic [TY_W-1:0]              ty,
   input  logic [N_ADDR-1:0][DA_W-1:0] slot_da,
   input  logic [N_ADDR-1:0]            slot_act,
   input  logic [N_TYPE-1:0][TY_W-1:0] slot_ty,
   input  logic [N_TYPE-1:0]            slot_ten,
   output logic [N_ADDR-1:0]            a_eq,
   output logic [N_TYPE-1:0]            t_eq
);
   for (genvar k = 0; k < N_ADDR; k++) begin : g_acmp
      assign a_eq[k] = slot_act[k] && (slot_da[k] == da);
   end
   for (genvar j = 0; j < N_TYPE; j++) begin : g_tcmp
      assign t_eq[j] = slot_ten[j] && (slot_ty[j] == ty);
   end
endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
   import eth_filt_pkg::*;
#(
   parameter int N_ADDR = 4,
   parameter int N_TYPE = 4,
   localparam int AW    = $clog2(2*N_ADDR + N_TYPE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              hd_mode,
   input  logic              tx_busy,
   input  logic              hd_rx_allow,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic [7:0]        rx_data,
   input  logic              rx_eof,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic [N_ADDR-1:0] dec_addr_hit,
   output logic [N_TYPE-1:0] dec_type_hit,
   output logic              dec_group,
   output logic              dec_bcast
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (N_ADDR < 1 || N_ADDR > 16) begin : g_chk_addr
      $error("N_ADDR out of range");
   end
   if (N_TYPE < 1 || N_TYPE > 16) begin : g_chk_type
      $error("N_TYPE out of range");
   end

   logic [N_ADDR-1:0][DA_W-1:0] s_da;
   logic [N_ADDR-1:0]           s_act;
   logic [N_TYPE-1:0][TY_W-1:0] s_ty;
   logic [N_TYPE-1:0]           s_ten;
   logic [N_ADDR-1:0]           a_eq;
   logic [N_TYPE-1:0]           t_eq;

   logic                take, byte_ok, in_frame, decided, blocked, grp_q, bc_q;
   logic [CNT_W-1:0]    cnt, idx;
   logic [DA_W-1:0]     da_q, da_cmp;
   logic [7:0]          ty_hi_q;
   logic [N_ADDR-1:0]   ahit;

   assign take    = rx_valid && rx_sof;
   assign byte_ok = rx_valid && (take || in_frame);
   assign idx     = take ? '0 : cnt;
   assign da_cmp  = {rx_data, da_q[DA_W-1:BYTE_W]};

   eth_filt_regs #(.N_ADDR(N_ADDR), .N_TYPE(N_TYPE), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .take(take), .snap_da(s_da), .snap_act(s_act), .snap_ty(s_ty), .snap_ten(s_ten)
   );

   eth_filt_cmp #(.N_ADDR(N_ADDR), .N_TYPE(N_TYPE)) u_cmp (
      .da(da_cmp), .ty({ty_hi_q, rx_data}), .slot_da(s_da), .slot_act(s_act),
      .slot_ty(s_ty), .slot_ten(s_ten), .a_eq(a_eq), .t_eq(t_eq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame     <= 1'b0;
         decided      <= 1'b0;
         blocked      <= 1'b0;
         grp_q        <= 1'b0;
         bc_q         <= 1'b0;
         cnt          <= '0;
         da_q         <= '0;
         ty_hi_q      <= '0;
         ahit         <= '0;
         dec_valid    <= 1'b0;
         dec_accept   <= 1'b0;
         dec_addr_hit <= '0;
         dec_type_hit <= '0;
         dec_group    <= 1'b0;
         dec_bcast    <= 1'b0;
      end else begin
         dec_valid    <= 1'b0;
         dec_accept   <= 1'b0;
         dec_addr_hit <= '0;
         dec_type_hit <= '0;
         dec_group    <= 1'b0;
         dec_bcast    <= 1'b0;
         if (take) begin
            in_frame <= 1'b1;
            decided  <= 1'b0;
            blocked  <= 1'b0;
            ahit     <= '0;
            grp_q    <= 1'b0;
            bc_q     <= 1'b0;
            cnt      <= CNT_W'(1);
         end else if (byte_ok && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
         end
         if (byte_ok) da_q <= da_cmp;
         if (byte_ok && idx == CNT_W'(IDX_DA_LAST)) begin
            ahit    <= a_eq;
            blocked <= hd_mode && tx_busy && !hd_rx_allow;
            grp_q   <= da_cmp[0];
            bc_q    <= &da_cmp;
         end
         if (byte_ok && idx == CNT_W'(IDX_TY_HI)) ty_hi_q <= rx_data;
         if (byte_ok && !take && idx == CNT_W'(IDX_TY_LO) && !decided) begin
            decided      <= 1'b1;
            dec_valid    <= 1'b1;
            dec_accept   <= ((|ahit) || (|t_eq)) && !blocked;
            dec_addr_hit <= ahit;
            dec_type_hit <= t_eq;
            dec_group    <= grp_q;
            dec_bcast    <= bc_q;
         end else if (rx_eof && in_frame && !decided) begin
            decided      <= 1'b1;
            dec_valid    <= 1'b1;
            dec_accept   <= (|ahit) && !blocked;
            dec_addr_hit <= ahit;
            dec_group    <= grp_q;
            dec_bcast    <= bc_q;
         end
         if (rx_eof) in_frame <= 1'b0;
      end
   end

   p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);
   p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> (!dec_accept && dec_addr_hit == '0 && dec_type_hit == '0));
   p_accept_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_accept |-> ((|dec_addr_hit) || (|dec_type_hit)));
   p_bcast_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dec_bcast |-> dec_group);
   p_eof_no_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_eof && in_frame && !decided && !rx_valid) |=> (dec_valid && dec_type_hit == '0));
endmodule

// File: tb/sim_eth_rx_filter.sv
`timescale 1ns/1ps
module sim_eth_rx_filter;
   typedef struct {
      bit       acc;
      bit [3:0] ah;
      bit [3:0] th;
      bit       g;
      bit       b;
      string    tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        hd_mode = 1'b0, tx_busy = 1'b0, hd_rx_allow = 1'b0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        dec_valid, dec_accept, dec_group, dec_bcast;
   logic [3:0]  dec_addr_hit, dec_type_hit;

   int checks = 0;
   int errors = 0;
   exp_t q[$];
   exp_t mon_e;

   bit [31:0] m_lo [4];
   bit [15:0] m_hi [4];
   bit        m_act[4];
   bit [31:0] m_ty [4];

   always #2.5 clk = ~clk;

   eth_rx_filter u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .hd_mode(hd_mode), .tx_busy(tx_busy), .hd_rx_allow(hd_rx_allow),
      .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data), .rx_eof(rx_eof),
      .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_addr_hit(dec_addr_hit),
      .dec_type_hit(dec_type_hit), .dec_group(dec_group), .dec_bcast(dec_bcast)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic void mwrite(input bit [3:0] a, input bit [31:0] d);
      if (a < 8) begin
         if (a[0] == 1'b0) begin m_lo[a[2:1]] = d; m_act[a[2:1]] = 1'b0; end
         else begin m_hi[a[2:1]] = d[15:0]; m_act[a[2:1]] = 1'b1; end
      end else if (a < 12) begin
         m_ty[a - 8] = d;
      end
   endfunction

   function automatic exp_t model(input bit [47:0] da, input bit [15:0] ty,
                                  input int len, input string tag);
      exp_t e;
      e.ah = '0; e.th = '0; e.g = 0; e.b = 0; e.tag = tag;
      for (int k = 0; k < 4; k++)
         if (len >= 6 && m_act[k] && da == {m_hi[k], m_lo[k]}) e.ah[k] = 1'b1;
      for (int j = 0; j < 4; j++)
         if (len >= 14 && m_ty[j][31] && ty == m_ty[j][15:0]) e.th[j] = 1'b1;
      if (len >= 6) begin e.g = da[0]; e.b = (da == '1); end
      e.acc = ((|e.ah) || (|e.th)) &&
              !(len >= 6 && hd_mode && tx_busy && !hd_rx_allow);
      return e;
   endfunction

   task automatic wr(input bit [3:0] a, input bit [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      mwrite(a, d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic frame(input bit [47:0] da, input bit [15:0] ty, input int len,
                        input string tag, input int wr_at = -1,
                        input bit [3:0] wa = 0, input bit [31:0] wd = 0);
      q.push_back(model(da, ty, len, tag));
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (i == 13) chk(dec_valid == 1'b0, "R6", "strobe before byte 14", dec_valid, 0);
         if (i == 14) chk(dec_valid == 1'b1, "R6", "strobe after byte 14", dec_valid, 1);
         rx_valid = 1'b1;
         rx_sof   = (i == 0);
         if (i < 6) rx_data = da[8*i +: 8];
         else if (i == 12) rx_data = ty[15:8];
         else if (i == 13) rx_data = ty[7:0];
         else rx_data = 8'(8'h10 + i);
         if (i == wr_at) begin
            cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd; mwrite(wa, wd);
         end else cfg_we = 1'b0;
      end
      @(negedge clk);
      if (len == 14) chk(dec_valid == 1'b1, "R6", "strobe after byte 14", dec_valid, 1);
      rx_valid = 1'b0; rx_sof = 1'b0; cfg_we = 1'b0; rx_eof = 1'b1;
      @(negedge clk);
      rx_eof = 1'b0;
      if (len < 14) chk(dec_valid == 1'b1, "R7", "strobe after end of frame", dec_valid, 1);
      repeat (3) @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (rst_n && dec_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R6", "unexpected strobe", 1, 0);
         end else begin
            mon_e = q.pop_front();
            chk({dec_accept, dec_addr_hit, dec_type_hit, dec_group, dec_bcast} ==
                {mon_e.acc, mon_e.ah, mon_e.th, mon_e.g, mon_e.b}, mon_e.tag,
                "acc/ahit/thit/grp/bc",
                {dec_accept, dec_addr_hit, dec_type_hit, dec_group, dec_bcast},
                {mon_e.acc, mon_e.ah, mon_e.th, mon_e.g, mon_e.b});
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   localparam bit [47:0] DA1 = 48'hCBA987654321;
   localparam bit [47:0] DAX = 48'h112233445566;

   initial begin
      for (int k = 0; k < 4; k++) begin m_lo[k] = 0; m_hi[k] = 0; m_act[k] = 0; m_ty[k] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dec_valid == 1'b0 && dec_accept == 1'b0, "R1", "reset outputs",
          {dec_valid, dec_accept}, 0);
      frame(DA1, 16'h4321, 20, "R1");
      // R2: example slot programming
      wr(4'd2, 32'h87654321); wr(4'd3, 32'h0000CBA9);
      frame(DA1, 16'h0800, 20, "R2");
      // R4: type slot 1 enabled by bit 31
      wr(4'd9, 32'h80004321);
      frame(DAX, 16'h4321, 16, "R4");
      // R11: disabled type slot never hits
      wr(4'd10, 32'h00001234);
      frame(DAX, 16'h1234, 14, "R11");
      // R3: low rewrite disarms, high rewrite re-arms
      wr(4'd2, 32'h87654321);
      frame(DA1, 16'h0800, 15, "R3");
      wr(4'd3, 32'h0000CBA9);
      frame(DA1, 16'h0800, 15, "R3");
      // R5: both kinds hit together
      frame(DA1, 16'h4321, 18, "R5");
      // R7: short frames
      frame(DA1, 16'h0000, 8, "R7");
      frame(DA1, 16'h0000, 3, "R7");
      frame(DAX, 16'h4321, 13, "R7");
      // R8: half duplex transmit blocking and its lifts
      hd_mode = 1'b1; tx_busy = 1'b1; hd_rx_allow = 1'b0;
      frame(DA1, 16'h4321, 16, "R8");
      hd_rx_allow = 1'b1;
      frame(DA1, 16'h0800, 16, "R8");
      hd_rx_allow = 1'b0; tx_busy = 1'b0;
      frame(DA1, 16'h0800, 16, "R8");
      hd_mode = 1'b0;
      // R9: broadcast and multicast flags
      wr(4'd0, 32'hFFFFFFFF); wr(4'd1, 32'h0000FFFF);
      frame(48'hFFFFFFFFFFFF, 16'h0800, 14, "R9");
      frame(48'h00005E000001, 16'h0800, 14, "R9");
      // R10: write during a frame applies to the next frame
      frame(DA1, 16'h0800, 20, "R10", 8, 4'd2, 32'h87654321);
      frame(DA1, 16'h0800, 20, "R10");
      wr(4'd3, 32'h0000CBA9);
      // R11: unused register indices change nothing
      wr(4'd13, 32'hFFFFFFFF); wr(4'd12, 32'h80000800);
      frame(DA1, 16'h0800, 16, "R11");
      repeat (4) @(negedge clk);
      chk(q.size() == 0, "R6", "decisions outstanding", q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule